// File: doc/BRIEF.md
# PCI Target Read Request Translator

This block sits behind the target side of a PCI interface and turns a decoded read request into a read on a 64-bit local system bus. On each request strobe it samples a command code, a 32-bit address and four active-low byte enables. From these it decides whether the local read is a single transfer or a fixed-length burst. It then forms the local address and byte-lane enables, and answers the PCI side with an acknowledge, a retry, or a stream of returned data beats.

The upper address bits pass through a substitution stage. Each bit selected by a mask register is replaced by the matching bit of a base register, and both registers are loaded through a small write port. Only one read can be outstanding at a time. The local slave can refuse the request with a rearbitrate indication, which the block passes back to the PCI side as a retry. Both sides use simple strobe or request/acknowledge handshakes.

Top module: `pci_rd_xlate`

## Requirements
- R1: While reset is active, and in the first cycle after it, lb_req_o, pci_ack_o, pci_retry_o, pci_data_valid_o and pci_done_o are all low.
- R2: A memory read command (code 4'h6) becomes a single local read with lb_burst_o=0 and lb_len_o=1. The inverted PCI byte enables go unchanged to byte lanes [3:0] when address bit 2 is 0, and to lanes [7:4] when it is 1. All other lanes are 0. pci_ack_o pulses in the first cycle lb_req_o is high.
- R3: For a single read, lb_addr_o bits [1:0] equal the index of the lowest asserted PCI byte enable (bit 0 is lane 0). Bits [23:2] are taken from the PCI address.
- R4: A single read with no byte enable asserted (pci_be_ni=4'hF) gives lb_addr_o[1:0]=00 and lb_be_o=0.
- R5: A memory read multiple command (code 4'hC) becomes a burst with lb_burst_o=1, lb_len_o=BURST_LEN, lb_addr_o[2:0]=000 and lb_be_o all ones, whatever byte enables were presented.
- R6: A memory read line command (code 4'hE) is handled exactly like memory read multiple.
- R7: Any other command, including I/O read (4'h2) and memory write (4'h7), causes no local request, no acknowledge and no retry.
- R8: If lb_rearb_i is high while lb_req_o is high, pci_retry_o pulses in the next cycle. lb_req_o falls and no data is returned.
- R9: An accepted read command that arrives while a read is outstanding produces a pci_retry_o pulse in the next cycle. The outstanding read continues unchanged.
- R10: Each lb_rvalid_i beat appears on pci_data_o with pci_data_valid_o one cycle later. pci_done_o accompanies only the final beat: the single beat of a single read, or beat BURST_LEN of a burst.
- R11: When cfg_we_i is high, cfg_sel_i=0 loads the base register and cfg_sel_i=1 loads the mask register. Both take cfg_wdata_i and map it onto address bits [31:24]. A later lb_addr_o carries base bits where the mask is 1 and PCI address bits where it is 0. Both registers reset to 0.
- R12: Once raised, lb_req_o and lb_addr_o, lb_be_o, lb_burst_o and lb_len_o hold steady until lb_ack_i or lb_rearb_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Substitution register write strobe |
| cfg_sel_i | input | 1 | 0 selects base, 1 selects mask |
| cfg_wdata_i | input | SUB_BITS | Substitution register write data |
| pci_req_i | input | 1 | PCI read request strobe |
| pci_cmd_i | input | 4 | PCI command code |
| pci_addr_i | input | ADDR_W | PCI address |
| pci_be_ni | input | 4 | First-phase byte enables, active low |
| pci_ack_o | output | 1 | Request accepted pulse |
| pci_retry_o | output | 1 | Retry pulse to PCI side |
| pci_data_o | output | DATA_W | Returned read data |
| pci_data_valid_o | output | 1 | pci_data_o holds a beat |
| pci_done_o | output | 1 | Final beat marker |
| lb_req_o | output | 1 | Local bus read request |
| lb_addr_o | output | ADDR_W | Local bus address |
| lb_be_o | output | DATA_W/8 | Local bus byte-lane enables |
| lb_burst_o | output | 1 | Request is a burst |
| lb_len_o | output | LEN_W | Beats requested |
| lb_ack_i | input | 1 | Local slave accepts request |
| lb_rearb_i | input | 1 | Local slave asks for rearbitration |
| lb_rdata_i | input | DATA_W | Local read data |
| lb_rvalid_i | input | 1 | Local read data valid |

## Verification
The assertions check several rules on every cycle. A pending request stays stable until the slave answers it. Bursts are always aligned and use all lanes. A single read uses at most one group of four lanes. A rearbitrate or a busy-time request is always followed by a retry, an unaccepted command never raises a request, and the done marker never appears without data. Other behaviour depends on chosen stimulus and only the bench scenarios show it. That includes choosing the low address bits from the byte enables, the empty-enable case, the effect of the base and mask registers, the read line mapping, and the exact beat on which done appears with gaps in the returned data.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;
  localparam logic [3:0] CMD_IO_RD       = 4'h2;
  localparam logic [3:0] CMD_MEM_RD      = 4'h6;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'hC;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'hE;

  typedef enum logic [1:0] {XFER_NONE, XFER_SINGLE, XFER_BURST} xfer_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA} rd_st_e;
endpackage

// File: rtl/pci_rd_subst.sv
module pci_rd_subst #(
  parameter int ADDR_W   = 32,
  parameter int SUB_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [SUB_BITS-1:0] cfg_wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LOW_W = ADDR_W - SUB_BITS;

  logic [SUB_BITS-1:0] base_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i) mask_q <= cfg_wdata_i;
      else           base_q <= cfg_wdata_i;
    end
  end

  assign addr_o = {(addr_i[ADDR_W-1 -: SUB_BITS] & ~mask_q) | (base_q & mask_q),
                   addr_i[LOW_W-1:0]};
endmodule

// File: rtl/pci_rd_decode.sv
module pci_rd_decode
  import pci_rd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int BE_W          = 8,
  parameter bit LINE_AS_BURST = 1'b1
) (
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_ni,
  output xfer_e             kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o
);
  localparam int GRP     = BE_W / 4;
  localparam int GSEL_W  = $clog2(GRP);
  localparam int ALIGN_W = $clog2(BE_W);

  xfer_e            line_kind;
  logic [3:0]       lanes;
  logic [1:0]       low2;
  logic [BE_W-1:0]  grp_be;

  generate
    if (LINE_AS_BURST) begin : g_line_burst
      assign line_kind = XFER_BURST;
    end else begin : g_line_single
      assign line_kind = XFER_SINGLE;
    end
  endgenerate

  always_comb begin
    case (cmd_i)
      CMD_MEM_RD:      kind_o = XFER_SINGLE;
      CMD_MEM_RD_MULT: kind_o = XFER_BURST;
      CMD_MEM_RD_LINE: kind_o = line_kind;
      default:         kind_o = XFER_NONE;
    endcase
  end

  assign lanes = ~be_ni;

  // lowest enabled lane gives the low address bits
  always_comb begin
    low2 = 2'b00;
    for (int i = 3; i >= 0; i--) begin
      if (lanes[i]) low2 = 2'(i);
    end
  end

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    assign grp_be[g*4 +: 4] = (addr_i[2 +: GSEL_W] == GSEL_W'(g)) ? lanes : 4'h0;
  end

  always_comb begin
    if (kind_o == XFER_BURST) begin
      addr_o = {addr_i[ADDR_W-1:ALIGN_W], ALIGN_W'(0)};
      be_o   = '1;
    end else begin
      addr_o = {addr_i[ADDR_W-1:2], low2};
      be_o   = (kind_o == XFER_SINGLE) ? grp_be : '0;
    end
  end
endmodule

// File: rtl/pci_rd_fsm.sv
module pci_rd_fsm
  import pci_rd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BURST_LEN = 4,
  localparam int BE_W     = DATA_W / 8,
  localparam int LEN_W    = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  xfer_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              lb_ack_i,
  input  logic              lb_rearb_i,
  input  logic [DATA_W-1:0] lb_rdata_i,
  input  logic              lb_rvalid_i,
  output logic              pci_ack_o,
  output logic              pci_retry_o,
  output logic [DATA_W-1:0] pci_data_o,
  output logic              pci_data_valid_o,
  output logic              pci_done_o,
  output logic              lb_req_o,
  output logic [ADDR_W-1:0] lb_addr_o,
  output logic [BE_W-1:0]   lb_be_o,
  output logic              lb_burst_o,
  output logic [LEN_W-1:0]  lb_len_o
);
  rd_st_e           st_q;
  logic [LEN_W-1:0] beat_q, last_beat;
  logic             take;

  assign take      = req_i && (kind_i != XFER_NONE);
  assign last_beat = lb_burst_o ? LEN_W'(BURST_LEN - 1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q             <= ST_IDLE;
      beat_q           <= '0;
      pci_ack_o        <= 1'b0;
      pci_retry_o      <= 1'b0;
      pci_data_o       <= '0;
      pci_data_valid_o <= 1'b0;
      pci_done_o       <= 1'b0;
      lb_addr_o        <= '0;
      lb_be_o          <= '0;
      lb_burst_o       <= 1'b0;
    end else begin
      pci_ack_o        <= 1'b0;
      pci_retry_o      <= 1'b0;
      pci_data_valid_o <= 1'b0;
      pci_done_o       <= 1'b0;
      case (st_q)
        ST_IDLE: if (take) begin
          st_q       <= ST_REQ;
          pci_ack_o  <= 1'b1;
          lb_addr_o  <= addr_i;
          lb_be_o    <= be_i;
          lb_burst_o <= (kind_i == XFER_BURST);
        end
        ST_REQ: begin
          if (lb_rearb_i) begin
            st_q        <= ST_IDLE;
            pci_retry_o <= 1'b1;
          end else if (lb_ack_i) begin
            st_q   <= ST_DATA;
            beat_q <= '0;
          end
        end
        ST_DATA: if (lb_rvalid_i) begin
          pci_data_valid_o <= 1'b1;
          pci_data_o       <= lb_rdata_i;
          if (beat_q == last_beat) begin
            pci_done_o <= 1'b1;
            st_q       <= ST_IDLE;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      // one read at a time
      if (st_q != ST_IDLE && take) pci_retry_o <= 1'b1;
    end
  end

  assign lb_req_o = (st_q == ST_REQ);
  assign lb_len_o = lb_burst_o ? LEN_W'(BURST_LEN) : LEN_W'(1);
endmodule

// File: rtl/pci_rd_xlate.sv
module pci_rd_xlate
  import pci_rd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SUB_BITS      = 8,
  parameter int DATA_W        = 64,
  parameter int BURST_LEN     = 4,
  parameter bit LINE_AS_BURST = 1'b1,
  localparam int BE_W         = DATA_W / 8,
  localparam int LEN_W        = $clog2(BURST_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic                cfg_sel_i,
  input  logic [SUB_BITS-1:0] cfg_wdata_i,
  input  logic                pci_req_i,
  input  logic [3:0]          pci_cmd_i,
  input  logic [ADDR_W-1:0]   pci_addr_i,
  input  logic [3:0]          pci_be_ni,
  output logic                pci_ack_o,
  output logic                pci_retry_o,
  output logic [DATA_W-1:0]   pci_data_o,
  output logic                pci_data_valid_o,
  output logic                pci_done_o,
  output logic                lb_req_o,
  output logic [ADDR_W-1:0]   lb_addr_o,
  output logic [BE_W-1:0]     lb_be_o,
  output logic                lb_burst_o,
  output logic [LEN_W-1:0]    lb_len_o,
  input  logic                lb_ack_i,
  input  logic                lb_rearb_i,
  input  logic [DATA_W-1:0]   lb_rdata_i,
  input  logic                lb_rvalid_i
);
  logic [ADDR_W-1:0] sub_addr, dec_addr;
  logic [BE_W-1:0]   dec_be;
  xfer_e             dec_kind;

  pci_rd_subst #(.ADDR_W(ADDR_W), .SUB_BITS(SUB_BITS)) u_subst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .addr_i      (pci_addr_i),
    .addr_o      (sub_addr)
  );

  pci_rd_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W), .LINE_AS_BURST(LINE_AS_BURST)) u_decode (
    .cmd_i  (pci_cmd_i),
    .addr_i (sub_addr),
    .be_ni  (pci_be_ni),
    .kind_o (dec_kind),
    .addr_o (dec_addr),
    .be_o   (dec_be)
  );

  pci_rd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_i            (pci_req_i),
    .kind_i           (dec_kind),
    .addr_i           (dec_addr),
    .be_i             (dec_be),
    .lb_ack_i         (lb_ack_i),
    .lb_rearb_i       (lb_rearb_i),
    .lb_rdata_i       (lb_rdata_i),
    .lb_rvalid_i      (lb_rvalid_i),
    .pci_ack_o        (pci_ack_o),
    .pci_retry_o      (pci_retry_o),
    .pci_data_o       (pci_data_o),
    .pci_data_valid_o (pci_data_valid_o),
    .pci_done_o       (pci_done_o),
    .lb_req_o         (lb_req_o),
    .lb_addr_o        (lb_addr_o),
    .lb_be_o          (lb_be_o),
    .lb_burst_o       (lb_burst_o),
    .lb_len_o         (lb_len_o)
  );
endmodule

// File: rtl/pci_rd_xlate_chk.sv
module pci_rd_xlate_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BURST_LEN = 4,
  localparam int BE_W     = DATA_W / 8,
  localparam int LEN_W    = $clog2(BURST_LEN + 1),
  localparam int ALIGN_W  = $clog2(BE_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pci_req_i,
  input logic [3:0]        pci_cmd_i,
  input logic              pci_ack_o,
  input logic              pci_retry_o,
  input logic              pci_data_valid_o,
  input logic              pci_done_o,
  input logic              lb_req_o,
  input logic [ADDR_W-1:0] lb_addr_o,
  input logic [BE_W-1:0]   lb_be_o,
  input logic              lb_burst_o,
  input logic [LEN_W-1:0]  lb_len_o,
  input logic              lb_ack_i,
  input logic              lb_rearb_i
);
  logic rd_cmd;
  assign rd_cmd = pci_req_i &&
                  (pci_cmd_i == 4'h6 || pci_cmd_i == 4'hC || pci_cmd_i == 4'hE);

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_req_o && !lb_ack_i && !lb_rearb_i |=>
      lb_req_o && $stable(lb_addr_o) && $stable(lb_be_o) && $stable(lb_burst_o));

  assert_burst_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_req_o && lb_burst_o |->
      lb_addr_o[ALIGN_W-1:0] == '0 && (&lb_be_o) && lb_len_o == LEN_W'(BURST_LEN));

  assert_single_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_req_o && !lb_burst_o |-> $countones(lb_be_o) <= 4 && lb_len_o == LEN_W'(1));

  assert_ack_with_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_ack_o |-> lb_req_o);

  assert_rearb_retry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_req_o && lb_rearb_i |=> pci_retry_o && !lb_req_o);

  assert_busy_retry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_req_o && rd_cmd |=> pci_retry_o);

  assert_no_spurious_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lb_req_o && !rd_cmd |=> !lb_req_o && !pci_ack_o);

  assert_done_has_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_done_o |-> pci_data_valid_o);
endmodule

bind pci_rd_xlate pci_rd_xlate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .pci_req_i        (pci_req_i),
  .pci_cmd_i        (pci_cmd_i),
  .pci_ack_o        (pci_ack_o),
  .pci_retry_o      (pci_retry_o),
  .pci_data_valid_o (pci_data_valid_o),
  .pci_done_o       (pci_done_o),
  .lb_req_o         (lb_req_o),
  .lb_addr_o        (lb_addr_o),
  .lb_be_o          (lb_be_o),
  .lb_burst_o       (lb_burst_o),
  .lb_len_o         (lb_len_o),
  .lb_ack_i         (lb_ack_i),
  .lb_rearb_i       (lb_rearb_i)
);

// File: tb/pci_rd_xlate_tb.sv
`timescale 1ns/1ps
module pci_rd_xlate_tb;
  localparam int BL = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        pci_req;
  logic [3:0]  pci_cmd, pci_be_n;
  logic [31:0] pci_addr;
  logic        pci_ack, pci_retry, pci_dv, pci_done;
  logic [63:0] pci_data;
  logic        lb_req, lb_burst, lb_ack, lb_rearb, lb_rvalid;
  logic [31:0] lb_addr;
  logic [7:0]  lb_be;
  logic [2:0]  lb_len;
  logic [63:0] lb_rdata;

  pci_rd_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .pci_req_i(pci_req), .pci_cmd_i(pci_cmd), .pci_addr_i(pci_addr), .pci_be_ni(pci_be_n),
    .pci_ack_o(pci_ack), .pci_retry_o(pci_retry), .pci_data_o(pci_data),
    .pci_data_valid_o(pci_dv), .pci_done_o(pci_done),
    .lb_req_o(lb_req), .lb_addr_o(lb_addr), .lb_be_o(lb_be), .lb_burst_o(lb_burst),
    .lb_len_o(lb_len), .lb_ack_i(lb_ack), .lb_rearb_i(lb_rearb),
    .lb_rdata_i(lb_rdata), .lb_rvalid_i(lb_rvalid)
  );

  int    n_chk = 0, n_fail = 0;
  string scen  = "R1";
  bit    finished = 0;

  // behavioural reference model
  int          m_st, m_beat;
  logic        m_ack, m_retry, m_dv, m_done, m_burst;
  logic [63:0] m_data;
  logic [31:0] m_addr;
  logic [7:0]  m_be, m_base, m_mask, t_up;
  logic [3:0]  t_lanes;
  int          t_lo;

  function automatic bit is_rd(logic [3:0] c);
    return c == 4'h6 || c == 4'hC || c == 4'hE;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_beat <= 0; m_ack <= 0; m_retry <= 0; m_dv <= 0; m_done <= 0;
      m_burst <= 0; m_data <= '0; m_addr <= '0; m_be <= '0; m_base <= '0; m_mask <= '0;
    end else begin
      m_ack <= 0; m_retry <= 0; m_dv <= 0; m_done <= 0;
      if (cfg_we) begin
        if (cfg_sel) m_mask <= cfg_wdata; else m_base <= cfg_wdata;
      end
      if (m_st != 0 && pci_req && is_rd(pci_cmd)) m_retry <= 1;
      if (m_st == 0) begin
        if (pci_req && is_rd(pci_cmd)) begin
          m_st  <= 1;
          m_ack <= 1;
          t_up = (pci_addr[31:24] & ~m_mask) | (m_base & m_mask);
          if (pci_cmd != 4'h6) begin
            m_burst <= 1;
            m_addr  <= {t_up, pci_addr[23:3], 3'b000};
            m_be    <= 8'hFF;
          end else begin
            m_burst <= 0;
            t_lo = 0;
            for (int i = 3; i >= 0; i--) if (!pci_be_n[i]) t_lo = i;
            t_lanes = ~pci_be_n;
            m_addr <= {t_up, pci_addr[23:2], 2'(t_lo)};
            m_be   <= pci_addr[2] ? {t_lanes, 4'h0} : {4'h0, t_lanes};
          end
        end
      end else if (m_st == 1) begin
        if (lb_rearb) begin m_retry <= 1; m_st <= 0; end
        else if (lb_ack) begin m_st <= 2; m_beat <= 0; end
      end else begin
        if (lb_rvalid) begin
          m_dv   <= 1;
          m_data <= lb_rdata;
          if (m_beat == (m_burst ? BL : 1) - 1) begin m_done <= 1; m_st <= 0; end
          else m_beat <= m_beat + 1;
        end
      end
    end
  end

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", scen, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("lb_req", 64'(lb_req), 64'(m_st == 1));
    if (m_st == 1) begin
      cmp("lb_addr", 64'(lb_addr), 64'(m_addr));
      cmp("lb_be", 64'(lb_be), 64'(m_be));
      cmp("lb_burst", 64'(lb_burst), 64'(m_burst));
      cmp("lb_len", 64'(lb_len), m_burst ? 64'(BL) : 64'd1);
    end
    cmp("pci_ack", 64'(pci_ack), 64'(m_ack));
    cmp("pci_retry", 64'(pci_retry), 64'(m_retry));
    cmp("pci_dv", 64'(pci_dv), 64'(m_dv));
    cmp("pci_done", 64'(pci_done), 64'(m_done));
    if (m_dv) cmp("pci_data", pci_data, m_data);
  endtask

  // local slave behaviour
  bit          sl_rearb = 0, sl_gaps = 0, sl_tog = 0;
  int          sl_wait_cfg = 0, sl_wait = 0, sl_left = 0;
  logic [63:0] sl_cnt = 64'hC0DE_0000_0000_0000;

  task automatic slave();
    lb_ack = 0; lb_rearb = 0; lb_rvalid = 0;
    if (sl_left > 0) begin
      sl_tog = ~sl_tog;
      if (!sl_gaps || sl_tog) begin
        lb_rvalid = 1;
        sl_cnt    = sl_cnt + 64'h1_0001;
        lb_rdata  = sl_cnt;
        sl_left--;
      end
    end else if (lb_req) begin
      if (sl_rearb) lb_rearb = 1;
      else if (sl_wait > 0) sl_wait--;
      else begin
        lb_ack  = 1;
        sl_left = lb_burst ? BL : 1;
        sl_wait = sl_wait_cfg;
      end
    end
  endtask

  task automatic step(bit req, logic [3:0] cmd, logic [31:0] addr, logic [3:0] be_n);
    @(negedge clk);
    check_all();
    slave();
    cfg_we = 0; pci_req = req; pci_cmd = cmd; pci_addr = addr; pci_be_n = be_n;
  endtask

  task automatic cfg(bit sel, logic [7:0] val);
    @(negedge clk);
    check_all();
    slave();
    pci_req = 0; cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 4'h0, 32'h0, 4'hF);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    pci_req = 0; pci_cmd = 0; pci_addr = 0; pci_be_n = 4'hF;
    lb_ack = 0; lb_rearb = 0; lb_rvalid = 0; lb_rdata = 0;
    scen = "R1";
    repeat (3) begin @(negedge clk); check_all(); end
    rst_n = 1;
    idle(2);

    scen = "R11";
    cfg(0, 8'hA5); cfg(1, 8'hF0);
    step(1, 4'h6, 32'h1234_5674, 4'b1011);  // lane 2, upper group
    idle(6);

    scen = "R3";
    step(1, 4'h6, 32'h0000_1238, 4'b1100);  // lane 0, lower group
    idle(6);
    step(1, 4'h6, 32'h0000_1230, 4'b0111);  // lane 3
    idle(6);

    scen = "R4";
    step(1, 4'h6, 32'h5555_5557, 4'b1111);
    idle(6);

    scen = "R2";
    sl_wait_cfg = 2; sl_wait = 2;
    step(1, 4'h6, 32'h8000_00A4, 4'b0101);
    idle(8);

    scen = "R5";
    sl_gaps = 1;
    step(1, 4'hC, 32'hFFFF_FFFF, 4'b0110);
    idle(16);

    scen = "R6";
    step(1, 4'hE, 32'h0101_0A0E, 4'b1110);
    idle(16);

    scen = "R7";
    step(1, 4'h2, 32'h0000_0010, 4'b0000);
    step(1, 4'h7, 32'h0000_0020, 4'b0000);
    step(1, 4'h0, 32'h0000_0030, 4'b0000);
    idle(3);

    scen = "R8";
    sl_rearb = 1;
    step(1, 4'h6, 32'h0000_4444, 4'b1101);
    idle(4);
    step(1, 4'hC, 32'h0000_4448, 4'b0000);
    idle(4);
    sl_rearb = 0;

    scen = "R9";
    sl_wait_cfg = 3; sl_wait = 3;
    step(1, 4'h6, 32'h0000_2004, 4'b1110);
    step(1, 4'hC, 32'h9999_0000, 4'b0000);  // arrives during request phase
    step(1, 4'h2, 32'h9999_0000, 4'b0000);  // ignored even while busy
    idle(3);
    step(1, 4'hE, 32'h9999_0008, 4'b0000);
    idle(10);
    sl_wait_cfg = 0; sl_wait = 0;
    step(1, 4'hC, 32'h0000_3000, 4'b0000);
    idle(3);
    step(1, 4'h6, 32'h0000_3010, 4'b1110);  // arrives during data phase
    idle(14);

    scen = "R10";
    sl_gaps = 0;
    step(1, 4'hC, 32'h0000_7000, 4'b0000);
    idle(8);
    step(1, 4'h6, 32'h0000_7004, 4'b1101);
    idle(5);

    scen = "R11";
    cfg(1, 8'h00);
    step(1, 4'h6, 32'h7700_0000, 4'b1110);
    idle(5);
    cfg(1, 8'hFF); cfg(0, 8'h3C);
    step(1, 4'hC, 32'h7700_0010, 4'b1111);
    idle(10);

    scen = "R12";
    sl_wait_cfg = 5; sl_wait = 5;
    step(1, 4'h6, 32'h0000_0102, 4'b1011);
    idle(10);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired in scenario %s", scen);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule